// File: doc/BRIEF.md
# Pixel Group Serializer with Overlay Resolution

This block sits between a frame-buffer datapath and a color lookup stage. A slow load strobe delivers a group of four or five pixels in parallel. Each pixel carries an 8-bit palette index and a 2-bit overlay code. Each group also carries one active-low blank control and one active-low sync control. On every rising edge of the strobe the whole group is captured. The block then plays the pixels out one per pixel clock, lane A first. For each pixel it decides whether the color comes from the main palette index or from one of four fixed overlay colors.

The strobe may run at any phase relative to the pixel clock. Captured groups stay in holding registers clocked by the strobe. A re-timed strobe edge in the pixel-clock domain copies the held group into the playout stage. A single command bit sets what overlay code zero means, and a mode input picks groups of four or five lanes.

Top module: `pix_ovl_serializer`

## Requirements
- R1: While reset is applied, and after reset until the first group reaches the outputs, `blank` is 1, `sync_n_out` is 1, `use_ovl` is 0, `ovl_num` is 0 and `pal_addr` is 0.
- R2: Lane k of a group occupies index bits [8k+7:8k] and overlay bits [2k+1:2k]. Lane A (k=0) is on the outputs after the fourth rising pixel-clock edge that follows the strobe's rising edge. The remaining lanes follow in ascending order, one per pixel clock.
- R3: When the group is not blanked, the overlay code is 0 and `cmd_pal0` is 1, the outputs are `use_ovl`=0, `ovl_num`=0 and `pal_addr` equal to the lane's palette index.
- R4: When the group is not blanked, the overlay code is 0 and `cmd_pal0` is 0, the outputs are `use_ovl`=1 and `ovl_num`=0. `pal_addr` is 0, so the index has no effect.
- R5: Overlay codes 1, 2 and 3 give `use_ovl`=1 and `ovl_num` equal to the code, whatever `cmd_pal0` is. `pal_addr` is 0 and the index is ignored.
- R6: When the captured `grp_blank_n` is 0, every pixel of that group shows `blank`=1, `use_ovl`=0, `ovl_num`=0 and `pal_addr`=0, whatever the index and overlay inputs are.
- R7: `sync_n_out` shows the captured `grp_sync_n` for every pixel of its group. This holds whether or not the group is blanked, and sync changes no other output.
- R8: `mode_five` is sampled when a group moves into the playout stage. It sets that group's length to 5 lanes (1) or 4 lanes (0). A change while a group is playing out does not cut or pad that group.
- R9: If no new group arrives after the last lane of a group, the outputs return to the idle values listed in R1.
- R10: The output stream and its latency are the same for any fixed strobe phase within the pixel-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_strobe | input | 1 | Group load strobe; its rising edge captures a group |
| mode_five | input | 1 | Group length select: 1 = five lanes, 0 = four lanes |
| cmd_pal0 | input | 1 | 1: overlay code 0 selects the palette index; 0: it selects overlay color 0 |
| grp_index | input | 40 | Palette indices, 8 bits per lane, lane A in the low bits |
| grp_ovl | input | 10 | Overlay codes, 2 bits per lane, lane A in the low bits |
| grp_blank_n | input | 1 | Active-low blank for the whole group |
| grp_sync_n | input | 1 | Active-low sync for the whole group |
| pal_addr | output | 8 | Palette address for the current pixel |
| ovl_num | output | 2 | Overlay color number for the current pixel |
| use_ovl | output | 1 | Pixel color comes from an overlay color |
| blank | output | 1 | Pixel is blanked or idle |
| sync_n_out | output | 1 | Active-low sync for the current pixel |

## Verification
On every cycle, the assertions check the rules that link the outputs to each other and to the command bit:
- a blanked pixel is fully zeroed;
- an overlay selection never carries an address;
- a palette selection or an overlay-zero selection agrees with the command bit of the previous cycle;
- the playout slot never passes the last lane of its group's length;
- an empty playout stage gives idle outputs.

Only the bench's scenarios can show the rest:
- lane order and the four-edge latency;
- correct capture of random groups at many strobe phases;
- per-group mode switching in mixed four/five bursts;
- sync passing through blanked groups.

// File: rtl/sov_pkg.sv
package sov_pkg;

  localparam int DEF_MAX_LANES = 5;
  localparam int DEF_IDX_W     = 8;
  localparam int DEF_OVL_W     = 2;

  // Group length latched with each group at transfer time
  typedef enum logic {
    LEN_SHORT = 1'b0,
    LEN_LONG  = 1'b1
  } grp_len_e;

endpackage

// File: rtl/sov_capture.sv
// Holding registers in the load-strobe domain. The group is frozen here
// until the pixel domain copies it, several pixel clocks later.
module sov_capture #(
  parameter int MAX_LANES = sov_pkg::DEF_MAX_LANES,
  parameter int IDX_W     = sov_pkg::DEF_IDX_W,
  parameter int OVL_W     = sov_pkg::DEF_OVL_W
) (
  input  logic                       ld_strobe,
  input  logic                       rst_n,
  input  logic [MAX_LANES*IDX_W-1:0] idx_in,
  input  logic [MAX_LANES*OVL_W-1:0] ovl_in,
  input  logic                       blank_n_in,
  input  logic                       sync_n_in,
  output logic [MAX_LANES*IDX_W-1:0] idx_hold,
  output logic [MAX_LANES*OVL_W-1:0] ovl_hold,
  output logic                       blank_n_hold,
  output logic                       sync_n_hold
);

  always_ff @(posedge ld_strobe or negedge rst_n) begin
    if (!rst_n) begin
      idx_hold     <= '0;
      ovl_hold     <= '0;
      blank_n_hold <= 1'b0;
      sync_n_hold  <= 1'b1;
    end else begin
      idx_hold     <= idx_in;
      ovl_hold     <= ovl_in;
      blank_n_hold <= blank_n_in;
      sync_n_hold  <= sync_n_in;
    end
  end

endmodule

// File: rtl/sov_sync.sv
// Pixel-domain reset release and strobe re-timing with rising-edge detect.
module sov_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_strobe,
  output logic rst_px_n,
  output logic load_evt
);

  logic rst_m1_q;
  logic rst_m2_q;
  logic ld_m1_q, ld_m2_q, ld_m3_q;
  logic ld_m1_d, ld_m2_d, ld_m3_d;

  // Reset asserts at once and is released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m1_q <= 1'b0;
      rst_m2_q <= 1'b0;
    end else begin
      rst_m1_q <= 1'b1;
      rst_m2_q <= rst_m1_q;
    end
  end

  assign rst_px_n = rst_m2_q;

  always_comb begin
    ld_m1_d = ld_strobe;
    ld_m2_d = ld_m1_q;
    ld_m3_d = ld_m2_q;
  end

  always_ff @(posedge clk or negedge rst_px_n) begin
    if (!rst_px_n) begin
      ld_m1_q <= 1'b0;
      ld_m2_q <= 1'b0;
      ld_m3_q <= 1'b0;
    end else begin
      ld_m1_q <= ld_m1_d;
      ld_m2_q <= ld_m2_d;
      ld_m3_q <= ld_m3_d;
    end
  end

  assign load_evt = ld_m2_q & ~ld_m3_q;

endmodule

// File: rtl/sov_shifter.sv
// Playout stage: holds one group and steps a lane slot once per clock.
module sov_shifter #(
  parameter int MAX_LANES = sov_pkg::DEF_MAX_LANES,
  parameter int IDX_W     = sov_pkg::DEF_IDX_W,
  parameter int OVL_W     = sov_pkg::DEF_OVL_W,
  localparam int SW       = $clog2(MAX_LANES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_evt,
  input  logic                       mode_five,
  input  logic [MAX_LANES*IDX_W-1:0] idx_hold,
  input  logic [MAX_LANES*OVL_W-1:0] ovl_hold,
  input  logic                       blank_n_hold,
  input  logic                       sync_n_hold,
  output logic [IDX_W-1:0]           cur_idx,
  output logic [OVL_W-1:0]           cur_code,
  output logic                       cur_blank_n,
  output logic                       cur_sync_n,
  output logic                       live,
  output logic [SW-1:0]              slot,
  output logic                       len_long
);

  localparam logic [SW-1:0] LAST_LONG  = SW'(MAX_LANES - 1);
  localparam logic [SW-1:0] LAST_SHORT = SW'(MAX_LANES - 2);

  logic [MAX_LANES*IDX_W-1:0] idx_q, idx_d;
  logic [MAX_LANES*OVL_W-1:0] ovl_q, ovl_d;
  logic                       bn_q, bn_d;
  logic                       sn_q, sn_d;
  sov_pkg::grp_len_e          len_q, len_d;
  logic [SW-1:0]              slot_q, slot_d;
  logic                       live_q, live_d;
  logic                       step_en;
  logic [SW-1:0]              last_slot;

  assign last_slot = (len_q == sov_pkg::LEN_LONG) ? LAST_LONG : LAST_SHORT;
  assign step_en   = load_evt | live_q;

  always_comb begin
    idx_d  = idx_q;
    ovl_d  = ovl_q;
    bn_d   = bn_q;
    sn_d   = sn_q;
    len_d  = len_q;
    slot_d = slot_q;
    live_d = live_q;
    if (load_evt) begin
      idx_d  = idx_hold;
      ovl_d  = ovl_hold;
      bn_d   = blank_n_hold;
      sn_d   = sync_n_hold;
      len_d  = sov_pkg::grp_len_e'(mode_five);
      slot_d = '0;
      live_d = 1'b1;
    end else if (live_q) begin
      if (slot_q == last_slot) begin
        live_d = 1'b0;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ovl_q  <= '0;
      bn_q   <= 1'b0;
      sn_q   <= 1'b1;
      len_q  <= sov_pkg::LEN_SHORT;
      slot_q <= '0;
      live_q <= 1'b0;
    end else if (step_en) begin
      idx_q  <= idx_d;
      ovl_q  <= ovl_d;
      bn_q   <= bn_d;
      sn_q   <= sn_d;
      len_q  <= len_d;
      slot_q <= slot_d;
      live_q <= live_d;
    end
  end

  logic [IDX_W-1:0] lane_idx [MAX_LANES];
  logic [OVL_W-1:0] lane_ovl [MAX_LANES];

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    assign lane_idx[g] = idx_q[g*IDX_W +: IDX_W];
    assign lane_ovl[g] = ovl_q[g*OVL_W +: OVL_W];
  end

  assign cur_idx     = lane_idx[slot_q];
  assign cur_code    = lane_ovl[slot_q];
  assign cur_blank_n = bn_q;
  assign cur_sync_n  = sn_q;
  assign live        = live_q;
  assign slot        = slot_q;
  assign len_long    = (len_q == sov_pkg::LEN_LONG);

endmodule

// File: rtl/sov_resolve.sv
// Per-pixel source decision and output register.
module sov_resolve #(
  parameter int IDX_W = sov_pkg::DEF_IDX_W,
  parameter int OVL_W = sov_pkg::DEF_OVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic [IDX_W-1:0] idx,
  input  logic [OVL_W-1:0] code,
  input  logic             blank_n_in,
  input  logic             sync_n_in,
  input  logic             cmd_pal0,
  output logic [IDX_W-1:0] pal_addr,
  output logic [OVL_W-1:0] ovl_num,
  output logic             use_ovl,
  output logic             blank,
  output logic             sync_n_out
);

  logic [IDX_W-1:0] addr_d;
  logic [OVL_W-1:0] num_d;
  logic             ovl_d, blank_d, sync_d;

  always_comb begin
    addr_d  = '0;
    num_d   = '0;
    ovl_d   = 1'b0;
    blank_d = 1'b1;
    sync_d  = 1'b1;
    if (live) begin
      sync_d = sync_n_in;
      if (blank_n_in) begin
        blank_d = 1'b0;
        if ((code == '0) && cmd_pal0) begin
          addr_d = idx;
        end else begin
          ovl_d = 1'b1;
          num_d = code;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_addr   <= '0;
      ovl_num    <= '0;
      use_ovl    <= 1'b0;
      blank      <= 1'b1;
      sync_n_out <= 1'b1;
    end else begin
      pal_addr   <= addr_d;
      ovl_num    <= num_d;
      use_ovl    <= ovl_d;
      blank      <= blank_d;
      sync_n_out <= sync_d;
    end
  end

endmodule

// File: rtl/pix_ovl_serializer.sv
module pix_ovl_serializer #(
  parameter int MAX_LANES = sov_pkg::DEF_MAX_LANES,
  parameter int IDX_W     = sov_pkg::DEF_IDX_W,
  parameter int OVL_W     = sov_pkg::DEF_OVL_W
) (
  input  logic                       clk_pix,
  input  logic                       rst_n,
  input  logic                       ld_strobe,
  input  logic                       mode_five,
  input  logic                       cmd_pal0,
  input  logic [MAX_LANES*IDX_W-1:0] grp_index,
  input  logic [MAX_LANES*OVL_W-1:0] grp_ovl,
  input  logic                       grp_blank_n,
  input  logic                       grp_sync_n,
  output logic [IDX_W-1:0]           pal_addr,
  output logic [OVL_W-1:0]           ovl_num,
  output logic                       use_ovl,
  output logic                       blank,
  output logic                       sync_n_out
);

  localparam int SW = $clog2(MAX_LANES);

  logic [MAX_LANES*IDX_W-1:0] idx_hold;
  logic [MAX_LANES*OVL_W-1:0] ovl_hold;
  logic                       bn_hold, sn_hold;
  logic                       rst_px_n, load_evt;
  logic [IDX_W-1:0]           cur_idx;
  logic [OVL_W-1:0]           cur_code;
  logic                       cur_bn, cur_sn, live;
  logic [SW-1:0]              slot;
  logic                       len_long;

  sov_capture #(.MAX_LANES(MAX_LANES), .IDX_W(IDX_W), .OVL_W(OVL_W)) u_cap (
    .ld_strobe    (ld_strobe),
    .rst_n        (rst_n),
    .idx_in       (grp_index),
    .ovl_in       (grp_ovl),
    .blank_n_in   (grp_blank_n),
    .sync_n_in    (grp_sync_n),
    .idx_hold     (idx_hold),
    .ovl_hold     (ovl_hold),
    .blank_n_hold (bn_hold),
    .sync_n_hold  (sn_hold)
  );

  sov_sync u_sync (
    .clk       (clk_pix),
    .rst_n     (rst_n),
    .ld_strobe (ld_strobe),
    .rst_px_n  (rst_px_n),
    .load_evt  (load_evt)
  );

  sov_shifter #(.MAX_LANES(MAX_LANES), .IDX_W(IDX_W), .OVL_W(OVL_W)) u_shift (
    .clk          (clk_pix),
    .rst_n        (rst_px_n),
    .load_evt     (load_evt),
    .mode_five    (mode_five),
    .idx_hold     (idx_hold),
    .ovl_hold     (ovl_hold),
    .blank_n_hold (bn_hold),
    .sync_n_hold  (sn_hold),
    .cur_idx      (cur_idx),
    .cur_code     (cur_code),
    .cur_blank_n  (cur_bn),
    .cur_sync_n   (cur_sn),
    .live         (live),
    .slot         (slot),
    .len_long     (len_long)
  );

  sov_resolve #(.IDX_W(IDX_W), .OVL_W(OVL_W)) u_res (
    .clk        (clk_pix),
    .rst_n      (rst_px_n),
    .live       (live),
    .idx        (cur_idx),
    .code       (cur_code),
    .blank_n_in (cur_bn),
    .sync_n_in  (cur_sn),
    .cmd_pal0   (cmd_pal0),
    .pal_addr   (pal_addr),
    .ovl_num    (ovl_num),
    .use_ovl    (use_ovl),
    .blank      (blank),
    .sync_n_out (sync_n_out)
  );

endmodule

// File: rtl/pix_ovl_serializer_chk.sv
module pix_ovl_serializer_chk #(
  parameter int MAX_LANES = sov_pkg::DEF_MAX_LANES,
  parameter int IDX_W     = sov_pkg::DEF_IDX_W,
  parameter int OVL_W     = sov_pkg::DEF_OVL_W,
  localparam int SW       = $clog2(MAX_LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_pal0,
  input logic [IDX_W-1:0] pal_addr,
  input logic [OVL_W-1:0] ovl_num,
  input logic             use_ovl,
  input logic             blank,
  input logic             sync_n_out,
  input logic             live,
  input logic [SW-1:0]    slot,
  input logic             len_long
);

  localparam logic [SW-1:0] LAST_LONG  = SW'(MAX_LANES - 1);
  localparam logic [SW-1:0] LAST_SHORT = SW'(MAX_LANES - 2);

  // R6: a blanked pixel carries no source selection
  a_r6_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (!use_ovl && ovl_num == '0 && pal_addr == '0));

  // R5: overlay selection never carries a palette address
  a_r5_ovl_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    use_ovl |-> (pal_addr == '0));

  // R3: a palette pick only happens with the command bit set
  a_r3_palette_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && !use_ovl) |-> ($past(cmd_pal0) && ovl_num == '0));

  // R4: overlay color 0 only appears with the command bit clear
  a_r4_ovl0_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ovl && ovl_num == '0) |-> !$past(cmd_pal0));

  // R2, R8: slot never passes the last lane of the latched length
  a_r2_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (slot <= (len_long ? LAST_LONG : LAST_SHORT)));

  // R9: an empty playout stage produces idle outputs next cycle
  a_r9_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (blank && sync_n_out));

endmodule

bind pix_ovl_serializer pix_ovl_serializer_chk #(
  .MAX_LANES(MAX_LANES), .IDX_W(IDX_W), .OVL_W(OVL_W)
) u_chk (
  .clk        (clk_pix),
  .rst_n      (rst_px_n),
  .cmd_pal0   (cmd_pal0),
  .pal_addr   (pal_addr),
  .ovl_num    (ovl_num),
  .use_ovl    (use_ovl),
  .blank      (blank),
  .sync_n_out (sync_n_out),
  .live       (live),
  .slot       (slot),
  .len_long   (len_long)
);

// File: tb/pix_ovl_serializer_test.sv
`timescale 1ns/1ps
module pix_ovl_serializer_test;
  localparam int ML = 5;
  localparam int IW = 8;
  localparam int OW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 1'b0;
  logic mode_five = 1'b0;
  logic cmd = 1'b0;
  logic [ML*IW-1:0] gidx = '0;
  logic [ML*OW-1:0] govl = '0;
  logic gbn = 1'b1;
  logic gsn = 1'b1;
  logic [IW-1:0] pal_addr;
  logic [OW-1:0] ovl_num;
  logic use_ovl, blank, sync_n_out;

  pix_ovl_serializer uut (
    .clk_pix(clk), .rst_n(rst_n), .ld_strobe(ld), .mode_five(mode_five),
    .cmd_pal0(cmd), .grp_index(gidx), .grp_ovl(govl), .grp_blank_n(gbn),
    .grp_sync_n(gsn), .pal_addr(pal_addr), .ovl_num(ovl_num),
    .use_ovl(use_ovl), .blank(blank), .sync_n_out(sync_n_out)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;
  bit any_sent = 0;
  bit cmd_walk = 0;

  bit          ev    [64];
  logic [IW-1:0] e_idx [64];
  logic [OW-1:0] e_code[64];
  bit          e_bn  [64];
  bit          e_sn  [64];

  // {blank, sync_n, use_ovl, ovl_num, addr}
  function automatic logic [12:0] model(input bit live, input logic [7:0] idx,
                                        input logic [1:0] code, input bit bn,
                                        input bit sn, input bit c);
    if (!live) return {1'b1, 1'b1, 1'b0, 2'b00, 8'h00};
    if (!bn) return {1'b1, sn, 1'b0, 2'b00, 8'h00};
    if (code == 2'b00 && c) return {1'b0, sn, 1'b0, 2'b00, idx};
    return {1'b0, sn, 1'b1, code, 8'h00};
  endfunction

  task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, got, exp);
    end
  endtask

  logic [12:0] got_v;
  assign got_v = {blank, sync_n_out, use_ovl, ovl_num, pal_addr};

  always @(negedge clk) begin
    int s;
    string tag;
    if (started && !done) begin
      s = cyc % 64;
      if (ev[s]) begin
        if (!e_bn[s]) tag = "R2 R6 blanked lane";
        else if (e_code[s] == 2'b00 && cmd) tag = "R2 R3 palette lane";
        else if (e_code[s] == 2'b00) tag = "R2 R4 overlay0 lane";
        else tag = "R2 R5 overlay lane";
        check(tag, got_v, model(1'b1, e_idx[s], e_code[s], e_bn[s], e_sn[s], cmd));
        check("R7 sync pass", {12'h0, sync_n_out}, {12'h0, e_sn[s]});
        ev[s] = 0;
      end else begin
        check(any_sent ? "R9 idle" : "R1 before first group", got_v,
              model(1'b0, 8'h0, 2'b0, 1'b0, 1'b0, 1'b0));
      end
      // cmd changes only here, after the check, so it is known at the next edge
      if (cmd_walk && ($urandom % 7 == 0)) cmd = ~cmd;
    end
  end

  // kind: 0 random, 1 forced blank, 2 all overlay codes zero
  task automatic send_group(input bit five, input real off, input int kind);
    int n;
    int c;
    int s;
    n = five ? 5 : 4;
    @(posedge clk);
    #0.2;
    for (int k = 0; k < ML; k++) begin
      gidx[k*IW +: IW] = IW'($urandom);
      govl[k*OW +: OW] = (kind == 2) ? 2'b00 : OW'($urandom);
    end
    gbn = (kind == 1) ? 1'b0 : ($urandom % 6 != 0);
    gsn = ($urandom % 3 != 0);
    mode_five = five;
    #(off - 0.2);
    ld = 1'b1;
    c = cyc;
    any_sent = 1;
    for (int k = 0; k < n; k++) begin
      s = (c + 4 + k) % 64;
      ev[s]     = 1;
      e_idx[s]  = gidx[k*IW +: IW];
      e_code[s] = govl[k*OW +: OW];
      e_bn[s]   = gbn;
      e_sn[s]   = gsn;
    end
    repeat (2) @(posedge clk);
    #off;
    ld = 1'b0;
    repeat (n - 3) @(posedge clk);
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    real off;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) ev[i] = 0;
    // R1: outputs idle while reset is held
    repeat (3) @(negedge clk);
    check("R1 reset state", got_v, model(1'b0, 8'h0, 2'b0, 1'b0, 1'b0, 1'b0));
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    started = 1;
    gap(4);
    // R3: command set, every code zero selects the palette index
    cmd = 1'b1;
    for (int g = 0; g < 3; g++) send_group(1'b1, 1.0, 2);
    gap(8);
    // R4: command clear, every code zero selects overlay color 0
    cmd = 1'b0;
    for (int g = 0; g < 3; g++) send_group(1'b0, 1.0, 2);
    gap(8);
    // R6, R7: blanked groups still carry sync
    for (int g = 0; g < 2; g++) send_group(g[0], 2.0, 1);
    gap(8);
    // R8: alternating lengths back to back; R10: extreme phases
    send_group(1'b1, 0.5, 0);
    send_group(1'b0, 0.5, 0);
    send_group(1'b1, 0.5, 0);
    gap(8);
    send_group(1'b0, 3.5, 0);
    send_group(1'b1, 3.5, 0);
    send_group(1'b0, 3.5, 0);
    gap(8);
    // single group then idle (R9)
    send_group(1'b0, 1.7, 0);
    gap(10);
    // random bursts, random phase per burst (R10), random lengths (R8), R5 codes
    cmd_walk = 1;
    for (int b = 0; b < 60; b++) begin
      int ng;
      off = 0.5 + real'($urandom % 31) * 0.1;
      ng = 1 + ($urandom % 6);
      for (int g = 0; g < ng; g++) send_group(bit'($urandom % 2), off, 0);
      gap(1 + ($urandom % 6));
    end
    gap(12);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule